// File: doc/BRIEF.md
# Byte-Strided Peripheral Transfer Sequencer

This block decodes and runs one instruction class of a CPU with a 16-bit data bus: a transfer that moves a data register to or from memory one byte at a time, touching every other byte address. Peripherals with 8-bit registers often sit on one lane of a 16-bit bus. Their registers therefore appear at alternate byte addresses, and this instruction reaches them without software packing. The block takes the opcode word, a 16-bit displacement and the values of the selected address and data registers. It then runs a fixed bus sequence: one prefetch slot, two or four byte cycles, and a second prefetch slot. For loads, it also returns a value to write back to the register file.

The value is handled big-endian. The most significant byte of the moved quantity goes to, or comes from, the lowest address. A word load changes only the low half of the destination register. Each bus slot, prefetch or byte cycle, is held until the bus acknowledges it.

The controller has five named states. `ST_IDLE` waits for `start` with a recognised opcode (the transition is *launch*). `ST_PF_HEAD` issues the leading prefetch (*head accepted* leads to `ST_XFER`). `ST_XFER` runs the byte cycles (*byte accepted* stays in this state until the last byte, and *last byte accepted* leads to `ST_PF_TAIL`). `ST_PF_TAIL` issues the trailing prefetch (*tail accepted* leads to `ST_FINISH`). `ST_FINISH` raises `done` for one clock and goes back to `ST_IDLE` (*retire*).

Top module: `bytelane_xfer_seq`

## Requirements
- R1: An opcode is recognised only when (opcode AND 0xF1F8) equals 0x0108 (load word), 0x0148 (load long), 0x0188 (store word) or 0x01C8 (store long). A `start` with any other opcode is ignored: no prefetch, no bus cycle, no `done`.
- R2: `an_idx` equals opcode bits 2..0 and `dn_idx` equals opcode bits 11..9. `wb_idx` presents the data register index captured at launch.
- R3: The first byte address is `areg_val` plus the sign-extended displacement, modulo 2^ADDR_W.
- R4: A word transfer makes exactly two byte cycles and a long transfer makes exactly four. Each byte address is 2 above the previous one.
- R5: Bytes move most significant first. A word store writes dreg[15:8] and then dreg[7:0]. A long store writes dreg[31:24] down to dreg[7:0].
- R6: A byte at an even address uses `bus_wdata[15:8]` / `bus_rdata[15:8]` with `bus_ub` high. A byte at an odd address uses bits 7..0 with `bus_lb` high. On a write, the unused lane is driven to zero.
- R7: Exactly one prefetch slot (`pf_req`) comes before the first byte cycle and exactly one comes after the last. `pf_req` and `bus_req` are never high together.
- R8: A pending `pf_req` or `bus_req` stays high, with address, direction and write data unchanged, until a clock edge at which `bus_ack` is high.
- R9: `done` is high for exactly one clock, in the cycle after the trailing prefetch is acknowledged.
- R10: For loads only, `wb_en` is high together with `done`. A long load returns the four bytes assembled big-endian. A word load returns the two bytes in bits 15..0 and the launch-time dreg[31:16] in bits 31..16. Stores never raise `wb_en`.
- R11: A `start` that arrives while a transfer is running is ignored. The running transfer completes unchanged.
- R12: After reset, `pf_req`, `bus_req`, `done` and `wb_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, sampled in idle |
| opcode | input | 16 | Instruction word |
| disp | input | 16 | Signed displacement |
| areg_val | input | ADDR_W | Value of the selected address register |
| dreg_val | input | 32 | Value of the selected data register |
| an_idx | output | 3 | Address register index from the opcode |
| dn_idx | output | 3 | Data register index from the opcode |
| pf_req | output | 1 | Prefetch slot request |
| bus_req | output | 1 | Byte cycle request |
| bus_we | output | 1 | Byte cycle is a write |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 16 | Write data, byte on its lane |
| bus_ub | output | 1 | Upper lane (even address) strobe |
| bus_lb | output | 1 | Lower lane (odd address) strobe |
| bus_rdata | input | 16 | Read data |
| bus_ack | input | 1 | Acknowledge for the current slot |
| wb_en | output | 1 | Register writeback strobe |
| wb_idx | output | 3 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `bus_ack` is high only while a prefetch or byte request is pending, and that `start` is a single-cycle pulse. They also assume that `opcode`, `disp`, `areg_val` and `dreg_val` are valid in the launch cycle. The bench's memory model raises `bus_ack` only after it has seen a request. It holds `bus_ack` for one edge and then drops it, with a configurable number of wait cycles before each acknowledge. The driver raises `start` for exactly one clock and applies all operand values in that same clock. Its only deliberate mid-transfer `start` tests that a busy sequencer ignores the pulse.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    localparam int WORD_BYTES  = 2;
    localparam int LONG_BYTES  = 4;
    localparam int BYTE_STRIDE = 2;
    localparam int LANES       = 2;

    localparam logic [15:0] OPC_MASK    = 16'hF1F8;
    localparam logic [15:0] OPC_LOAD_W  = 16'h0108;
    localparam logic [15:0] OPC_LOAD_L  = 16'h0148;
    localparam logic [15:0] OPC_STORE_W = 16'h0188;
    localparam logic [15:0] OPC_STORE_L = 16'h01C8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PF_HEAD,
        ST_XFER,
        ST_PF_TAIL,
        ST_FINISH
    } bxs_state_e;

    typedef struct packed {
        logic       valid;
        logic       to_mem;
        logic       is_long;
        logic [2:0] dn;
        logic [2:0] an;
    } bxs_dec_t;

endpackage

// File: rtl/bxs_decode.sv
module bxs_decode
    import bxs_pkg::*;
(
    input  logic [15:0] opcode,
    output bxs_dec_t    dec
);

    always_comb begin
        dec         = '0;
        dec.dn      = opcode[11:9];
        dec.an      = opcode[2:0];
        case (opcode & OPC_MASK)
            OPC_LOAD_W: begin
                dec.valid   = 1'b1;
            end
            OPC_LOAD_L: begin
                dec.valid   = 1'b1;
                dec.is_long = 1'b1;
            end
            OPC_STORE_W: begin
                dec.valid   = 1'b1;
                dec.to_mem  = 1'b1;
            end
            OPC_STORE_L: begin
                dec.valid   = 1'b1;
                dec.to_mem  = 1'b1;
                dec.is_long = 1'b1;
            end
            default: begin
                dec.valid   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bxs_addr_gen.sv
module bxs_addr_gen
    import bxs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [15:0]       disp,
    output logic [ADDR_W-1:0] addr
);

    localparam int EXT_W = ADDR_W - 16;

    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp[15]}}, disp};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base + disp_ext;
        end else if (step) begin
            addr <= addr + ADDR_W'(BYTE_STRIDE);
        end
    end

    AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> addr == $past(addr) + ADDR_W'(BYTE_STRIDE)); // R4

endmodule

// File: rtl/bxs_byte_lanes.sv
module bxs_byte_lanes
    import bxs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        load_to_mem,
    input  logic        load_long,
    input  logic [31:0] dreg,
    input  logic        step,
    input  logic        to_mem_q,
    input  logic        long_q,
    input  logic        active,
    input  logic        byte_odd,
    input  logic [15:0] rdata,
    output logic [15:0] wdata,
    output logic        strobe_hi,
    output logic        strobe_lo,
    output logic [31:0] result
);

    logic [31:0]      shreg;
    logic [15:0]      keep_hi;
    logic [7:0]       cur_byte;
    logic [7:0]       rd_byte;
    logic [LANES-1:0] lane_sel;

    assign cur_byte = shreg[31:24];
    assign rd_byte  = byte_odd ? rdata[7:0] : rdata[15:8];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic LANE_ODD = (g == 0);
        assign lane_sel[g]       = active && (byte_odd == LANE_ODD);
        assign wdata[g*8 +: 8]   = (lane_sel[g] && to_mem_q) ? cur_byte : 8'h00;
    end

    assign strobe_hi = lane_sel[1];
    assign strobe_lo = lane_sel[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            keep_hi <= '0;
        end else if (load) begin
            keep_hi <= dreg[31:16];
            if (load_to_mem) begin
                shreg <= load_long ? dreg : {dreg[15:0], 16'h0000};
            end else begin
                shreg <= '0;
            end
        end else if (step) begin
            shreg <= to_mem_q ? {shreg[23:0], 8'h00} : {shreg[23:0], rd_byte};
        end
    end

    assign result = long_q ? shreg : {keep_hi, shreg[15:0]};

    AST_LANE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_hi && strobe_lo)); // R6

endmodule

// File: rtl/bxs_fsm.sv
module bxs_fsm
    import bxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_valid,
    input  logic long_q,
    input  logic bus_ack,
    output logic load,
    output logic pf_req,
    output logic bus_req,
    output logic step,
    output logic finish
);

    localparam int CW = $clog2(LONG_BYTES);

    bxs_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last_idx;
    logic          last_byte;

    assign last_idx  = long_q ? CW'(LONG_BYTES - 1) : CW'(WORD_BYTES - 1);
    assign last_byte = (cnt == last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_PF_HEAD) begin
                cnt <= '0;
            end else if (state == ST_XFER && bus_ack) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start && op_valid)          nxt = ST_PF_HEAD;
            ST_PF_HEAD: if (bus_ack)                    nxt = ST_XFER;
            ST_XFER:    if (bus_ack && last_byte)       nxt = ST_PF_TAIL;
            ST_PF_TAIL: if (bus_ack)                    nxt = ST_FINISH;
            ST_FINISH:                                  nxt = ST_IDLE;
            default:                                    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        pf_req  = 1'b0;
        bus_req = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        unique case (state)
            ST_IDLE:    load    = start && op_valid;
            ST_PF_HEAD: pf_req  = 1'b1;
            ST_XFER: begin
                bus_req = 1'b1;
                step    = bus_ack;
            end
            ST_PF_TAIL: pf_req  = 1'b1;
            ST_FINISH:  finish  = 1'b1;
            default:    finish  = 1'b0;
        endcase
    end

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pf_req && bus_req)); // R7
    AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req && !bus_ack |=> pf_req); // R8
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cnt <= last_idx); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish); // R9
    AST_HEAD_TO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(pf_req)); // R7

endmodule

// File: rtl/bytelane_xfer_seq.sv
module bytelane_xfer_seq
    import bxs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       opcode,
    input  logic [15:0]       disp,
    input  logic [ADDR_W-1:0] areg_val,
    input  logic [31:0]       dreg_val,
    output logic [2:0]        an_idx,
    output logic [2:0]        dn_idx,
    output logic              pf_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    output logic              bus_ub,
    output logic              bus_lb,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ack,
    output logic              wb_en,
    output logic [2:0]        wb_idx,
    output logic [31:0]       wb_data,
    output logic              done
);

    bxs_dec_t    dec;
    logic        load, step, finish;
    logic        to_mem_q, long_q;
    logic [2:0]  dn_q;

    bxs_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    assign an_idx = dec.an;
    assign dn_idx = dec.dn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_mem_q <= 1'b0;
            long_q   <= 1'b0;
            dn_q     <= '0;
        end else if (load) begin
            to_mem_q <= dec.to_mem;
            long_q   <= dec.is_long;
            dn_q     <= dec.dn;
        end
    end

    bxs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_valid (dec.valid),
        .long_q   (long_q),
        .bus_ack  (bus_ack),
        .load     (load),
        .pf_req   (pf_req),
        .bus_req  (bus_req),
        .step     (step),
        .finish   (finish)
    );

    bxs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .base  (areg_val),
        .disp  (disp),
        .addr  (bus_addr)
    );

    bxs_byte_lanes u_lanes (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_to_mem (dec.to_mem),
        .load_long   (dec.is_long),
        .dreg        (dreg_val),
        .step        (step),
        .to_mem_q    (to_mem_q),
        .long_q      (long_q),
        .active      (bus_req),
        .byte_odd    (bus_addr[0]),
        .rdata       (bus_rdata),
        .wdata       (bus_wdata),
        .strobe_hi   (bus_ub),
        .strobe_lo   (bus_lb),
        .result      (wb_data)
    );

    assign bus_we = bus_req && to_mem_q;
    assign done   = finish;
    assign wb_en  = finish && !to_mem_q;
    assign wb_idx = dn_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
            && $stable(bus_wdata)); // R8
    AST_LANE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_ub == !bus_addr[0]) && (bus_lb == bus_addr[0])); // R6
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done); // R10
    AST_DONE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(pf_req) && $past(bus_ack)); // R9

endmodule

// File: tb/bytelane_xfer_seq_test.sv
module bytelane_xfer_seq_test;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [7:0]  data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] disp = '0;
    logic [31:0] areg_val = '0;
    logic [31:0] dreg_val = '0;
    logic [2:0]  an_idx, dn_idx, wb_idx;
    logic        pf_req, bus_req, bus_we, bus_ub, bus_lb, wb_en, done;
    logic [31:0] bus_addr, wb_data;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    int pf_seen = 0;
    int byte_seen = 0;
    int done_seen = 0;
    int pf_at_first_byte = 0;
    item_t exp_q[$];
    logic [7:0] mem [logic [31:0]];

    always #10 clk = ~clk;

    bytelane_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .disp(disp),
        .areg_val(areg_val), .dreg_val(dreg_val), .an_idx(an_idx), .dn_idx(dn_idx),
        .pf_req(pf_req), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ub(bus_ub), .bus_lb(bus_lb), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and monitor: acknowledges requests and compares against the queue
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0;
            wcnt    = wait_cfg;
        end else begin
            if (done) done_seen++;
            if (bus_ack) begin
                bus_ack = 1'b0;
                wcnt    = wait_cfg;
            end else if (pf_req || bus_req) begin
                if (wcnt > 0) begin
                    wcnt--;
                end else begin
                    bus_ack = 1'b1;
                    if (pf_req) begin
                        pf_seen++;
                    end else begin
                        item_t e;
                        logic [7:0] b;
                        if (byte_seen == 0) pf_at_first_byte = pf_seen;
                        byte_seen++;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R4 extra byte cycle", bus_addr, 32'h0);
                        end else begin
                            e = exp_q.pop_front();
                            check(bus_addr == e.addr, "R3/R4 byte address", bus_addr, e.addr);
                            check(bus_we == e.we, "R1 direction", {31'h0, bus_we}, {31'h0, e.we});
                            check(bus_ub == !e.addr[0] && bus_lb == e.addr[0], "R6 strobes",
                                  {30'h0, bus_ub, bus_lb}, {30'h0, !e.addr[0], e.addr[0]});
                            if (e.we) begin
                                logic [15:0] w;
                                w = e.addr[0] ? {8'h00, e.data} : {e.data, 8'h00};
                                check(bus_wdata == w, "R5/R6 write data", {16'h0, bus_wdata},
                                      {16'h0, w});
                            end else begin
                                b = mem[e.addr];
                                bus_rdata = e.addr[0] ? {~b, b} : {b, ~b};
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic run_op(input logic [15:0] op, input logic [15:0] d, input logic [31:0] an,
                          input logic [31:0] dn, input int ws, input bit disturb);
        logic [31:0] ea;
        logic [31:0] exp_wb;
        bit          st, lng;
        int          n, guard;
        ea  = an + {{16{d[15]}}, d};
        st  = op[7];
        lng = op[6];
        n   = lng ? 4 : 2;
        exp_wb = lng ? 32'h0 : {dn[31:16], 16'h0};
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.we   = st;
            it.addr = ea + 32'(2 * k);
            if (st) begin
                it.data = lng ? dn[(3 - k) * 8 +: 8] : dn[(1 - k) * 8 +: 8];
            end else begin
                it.data = 8'h5C ^ it.addr[7:0] ^ 8'(k * 37);
                mem[it.addr] = it.data;
                exp_wb[(n - 1 - k) * 8 +: 8] = it.data;
            end
            exp_q.push_back(it);
        end
        wait_cfg  = ws;
        pf_seen   = 0;
        byte_seen = 0;
        done_seen = 0;
        @(negedge clk);
        opcode = op; disp = d; areg_val = an; dreg_val = dn; start = 1'b1;
        #1;
        check(an_idx == op[2:0], "R2 an_idx", {29'h0, an_idx}, {29'h0, op[2:0]});
        check(dn_idx == op[11:9], "R2 dn_idx", {29'h0, dn_idx}, {29'h0, op[11:9]});
        @(negedge clk);
        start = 1'b0; opcode = 16'h0000; areg_val = 32'hDEAD_0000; dreg_val = 32'h0BAD_F00D;
        if (disturb) begin
            repeat (3) @(negedge clk);
            opcode = 16'h01C8; areg_val = 32'h0000_7000; start = 1'b1;   // R11 stray start
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R9 done reached", {31'h0, done}, 32'h1);
        check(pf_seen == 2, "R7 prefetch count", 32'(pf_seen), 32'd2);
        check(pf_at_first_byte == 1, "R7 head prefetch first", 32'(pf_at_first_byte), 32'd1);
        check(byte_seen == n, "R4 byte count", 32'(byte_seen), 32'(n));
        check(exp_q.size() == 0, "R4 missing bytes", 32'(exp_q.size()), 32'd0);
        if (st) begin
            check(wb_en == 1'b0, "R10 no writeback on store", {31'h0, wb_en}, 32'h0);
        end else begin
            check(wb_en == 1'b1, "R10 writeback strobe", {31'h0, wb_en}, 32'h1);
            check(wb_data == exp_wb, "R10 writeback value", wb_data, exp_wb);
            check(wb_idx == op[11:9], "R2 wb_idx", {29'h0, wb_idx}, {29'h0, op[11:9]});
        end
        @(negedge clk);
        check(done == 1'b0 && wb_en == 1'b0, "R9 one-cycle done", {30'h0, done, wb_en}, 32'h0);
        repeat (8) @(negedge clk);
        check(!pf_req && !bus_req && done_seen == 1, "R11 no second run",
              {30'h0, pf_req, bus_req}, 32'h0);
        exp_q.delete();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!pf_req && !bus_req && !done && !wb_en, "R12 reset outputs",
              {28'h0, pf_req, bus_req, done, wb_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 unrecognised opcodes are ignored
        pf_seen = 0; byte_seen = 0; done_seen = 0;
        opcode = 16'h0100; start = 1'b1;
        @(negedge clk);
        opcode = 16'h0110;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(pf_seen == 0 && byte_seen == 0 && done_seen == 0, "R1 illegal ignored",
              32'(pf_seen + byte_seen + done_seen), 32'h0);

        // R5 word store, even base
        run_op(16'h0188 | 16'h0A03, 16'h0010, 32'h0000_1000, 32'hCAFE_1234, 0, 1'b0);
        // R5 long store, odd base, wait states
        run_op(16'h01C8 | 16'h0005, 16'h0004, 32'h0000_2001, 32'h8899_AABB, 2, 1'b0);
        // R10 word load keeps upper half; R3 negative displacement
        run_op(16'h0108 | 16'h0E01, 16'hFFF0, 32'h0000_3000, 32'h7654_3210, 1, 1'b0);
        // R10 long load, R3 wrap through zero, odd addresses
        run_op(16'h0148 | 16'h0207, 16'h0002, 32'hFFFF_FFFD, 32'h1111_2222, 0, 1'b0);
        // R11 stray start during a long load
        run_op(16'h0148 | 16'h0602, 16'h0100, 32'h0000_4000, 32'h0, 3, 1'b1);
        // R8 long wait states on a word load at odd base
        run_op(16'h0108, 16'h0003, 32'h0000_5000, 32'hA5A5_5A5A, 5, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule